// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

This block is a 32-pin general-purpose I/O port with a plain register bus. The bus has a write strobe, a word address, write data and read data that follows the address in the same cycle. Each pin drives its output-data bit when its direction bit is set. The live pin levels are sampled through a two-flop synchroniser and can be read back from a pad-level register. The output-data register always reads back the value that was last written to it.

Every pin has its own interrupt sensing. A 2-bit mode field selects low level, high level, rising edge or falling edge. The fields for pins 0-15 sit in one configuration register and the fields for pins 16-31 sit in a second one. A per-pin any-edge bit overrides the mode field and triggers on both transitions. Detected events latch into a sticky status register that is cleared by writing ones to it. An enable mask gates the status onto two interrupt lines: one line serves the lower sixteen pins and the other serves the upper sixteen.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register (output data, direction, both mode registers, any-edge, enable, status) reads zero, and both interrupt lines and all output enables are low.
- R2: The output-data register is at offset 0x00. A read returns the last value written, whatever the pin levels are, and `pad_out` carries the same value.
- R3: The direction register is at offset 0x04. `pad_oe[p]` is 1 exactly when direction bit p is 1.
- R4: The pad-level register at offset 0x08 returns `pad_in` after two clock edges. A change is not visible after one edge.
- R5: The mode register for pins 0-15 is at 0x0C and the one for pins 16-31 is at 0x10. Pin p uses bits [2*(p mod 16)+1 : 2*(p mod 16)]. Code 0 means low level, 1 means high level, 2 means rising edge and 3 means falling edge.
- R6: A pin in a level mode sets its status bit on every cycle the level is present. This includes the cycle right after a write that clears it.
- R7: A pin in an edge mode sets its status bit only on the selected transition of the synchronised input. A steady level, or the opposite edge, leaves the bit clear.
- R8: When the pin's bit in the any-edge register (0x1C) is 1, both transitions set the status bit and the mode field is ignored.
- R9: The status register (0x18) clears each bit written with 1. Bits written with 0 keep their value.
- R10: The enable register is at 0x14. `irq_lo` is the OR over pins 0-15 of (status AND enable), and `irq_hi` is the same OR over pins 16-31.
- R11: A read from any offset above 0x1C returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Pin output data |
| pad_oe | output | 32 | Pin output enables |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The hardest case to reach is a clear that lands while a level condition still holds, next to edge-mode pins whose bits must stay clear with the same pin values. This shows that setting wins over clearing only where a level is present. The bench holds each pin steady across a full clear, then moves it to a second value. The expected status therefore depends on both values and on all four modes together. Random mode words, any-edge bits and pin patterns are mixed with directed sequences that clear a held level, clear status bits partially, and split the enable mask across the two halves.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int HALF = NPINS / 2;
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(8'h1C);

  logic [NPINS-1:0] dout_q, dir_q, mlo_q, mhi_q, en_q, stat_q, any_q;
  logic [NPINS-1:0] s1_q, s2_q, prev_q;
  logic [NPINS-1:0] hit, clr;

  assign clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      en_q   <= '0;
      any_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DOUT:  dout_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_MLO:   mlo_q  <= bus_wdata;
        A_MHI:   mhi_q  <= bus_wdata;
        A_EN:    en_q   <= bus_wdata;
        A_ANY:   any_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = mlo_q[2*p +: 2];
    end else begin : g_hi
      assign mode = mhi_q[2*(p-HALF) +: 2];
    end
    assign hit[p] = any_q[p]     ? (s2_q[p] ^ prev_q[p]) :
                    (mode == 2'd0) ? ~s2_q[p] :
                    (mode == 2'd1) ?  s2_q[p] :
                    (mode == 2'd2) ? (s2_q[p] & ~prev_q[p]) :
                                     (~s2_q[p] & prev_q[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr) | hit;
  end

  always_comb begin
    case (bus_addr)
      A_DOUT:  bus_rdata = dout_q;
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = s2_q;
      A_MLO:   bus_rdata = mlo_q;
      A_MHI:   bus_rdata = mhi_q;
      A_EN:    bus_rdata = en_q;
      A_STAT:  bus_rdata = stat_q;
      A_ANY:   bus_rdata = any_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |(stat_q[HALF-1:0] & en_q[HALF-1:0]);
  assign irq_hi  = |(stat_q[NPINS-1:HALF] & en_q[NPINS-1:HALF]);

  // R9
  stat_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q)) & ~$past(clr)) == '0);

  // R2
  dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DOUT) |=> pad_out == $past(bus_wdata));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> pad_oe == $past(bus_wdata));

  // R10
  irq_quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_lo && !irq_hi));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > A_ANY) |-> bus_rdata == '0);

  // R8
  any_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((any_q & (s2_q ^ prev_q)) != '0) |=> ((stat_q & $past(any_q & (s2_q ^ prev_q))) == $past(any_q & (s2_q ^ prev_q))));

endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] a, b, lo, hi, any);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      logic [1:0] m;
      m = (p < 16) ? lo[2*p +: 2] : hi[2*(p-16) +: 2];
      if (any[p]) r[p] = a[p] ^ b[p];
      else case (m)
        2'd0: r[p] = ~a[p] | ~b[p];
        2'd1: r[p] =  a[p] |  b[p];
        2'd2: r[p] = ~a[p] &  b[p];
        default: r[p] = a[p] & ~b[p];
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(6'(a*4), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    chk("R1 reset oe", pad_oe, 32'h0);
    rst_n = 1;

    // R2 / R3
    wr(6'h00, 32'hA5C3_0F1E);
    wr(6'h04, 32'hFFFF_0000);
    pad_in = 32'h1234_5678;
    rd(6'h00, v);
    chk("R2 data readback", v, 32'hA5C3_0F1E);
    chk("R2 pad_out", pad_out, 32'hA5C3_0F1E);
    chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);

    // R4: two-edge latency
    settle(32'h0000_0000);
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk); rd(6'h08, v);
    chk("R4 pad after one edge", v, 32'h0);
    @(negedge clk); rd(6'h08, v);
    chk("R4 pad after two edges", v, 32'hDEAD_BEEF);

    // R11
    rd(6'h20, v); chk("R11 unmapped 0x20", v, 32'h0);
    rd(6'h3C, v); chk("R11 unmapped 0x3C", v, 32'h0);

    // R6: high level held across clear
    wr(6'h0C, 32'h5555_5555); wr(6'h10, 32'h5555_5555);
    settle(32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R6 level re-set after clear", v, 32'hFFFF_FFFF);

    // R7: rising mode stays clear on steady level and on falling edge
    wr(6'h0C, 32'hAAAA_AAAA); wr(6'h10, 32'hAAAA_AAAA);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R7 rising steady", v, 32'h0);
    settle(32'h0000_0000);
    rd(6'h18, v); chk("R7 rising ignores fall", v, 32'h0);
    settle(32'h00F0_000F);
    rd(6'h18, v); chk("R7 rising edge", v, 32'h00F0_000F);

    // R9: partial clear
    wr(6'h18, 32'h0000_0003);
    rd(6'h18, v); chk("R9 partial clear", v, 32'h00F0_000C);
    wr(6'h18, 32'h0);
    rd(6'h18, v); chk("R9 zero write keeps", v, 32'h00F0_000C);

    // R10: halves of enable mask
    wr(6'h14, 32'h0010_0000);
    chk("R10 upper only", {30'h0, irq_hi, irq_lo}, 32'h2);
    wr(6'h14, 32'h0000_0004);
    chk("R10 lower only", {30'h0, irq_hi, irq_lo}, 32'h1);
    wr(6'h14, 32'h0000_0003);
    chk("R10 cleared bits quiet", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R8: any-edge overrides rising mode on a falling edge
    wr(6'h1C, 32'h8000_0001);
    wr(6'h18, 32'hFFFF_FFFF);
    settle(32'h0000_0000);
    rd(6'h18, v); chk("R8 any-edge on fall", v, 32'h0000_0001);
    wr(6'h1C, 32'h0);

    // R5..R10: random modes and pin pairs
    for (int t = 0; t < 60; t++) begin
      logic [31:0] a, b, lo, hi, any, en, e;
      a = $urandom; b = $urandom; lo = $urandom; hi = $urandom;
      any = $urandom & $urandom; en = $urandom;
      settle(a);
      wr(6'h0C, lo); wr(6'h10, hi); wr(6'h1C, any); wr(6'h14, en);
      repeat (2) @(negedge clk);
      wr(6'h18, 32'hFFFF_FFFF);
      settle(b);
      e = exp_stat(a, b, lo, hi, any);
      rd(6'h18, v); chk("R5 R6 R7 R8 random status", v, e);
      chk("R10 random irq", {30'h0, irq_hi, irq_lo},
          {30'h0, |(e[31:16] & en[31:16]), |(e[15:0] & en[15:0])});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule